// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Latched Reset-Switch Line

This block gathers 32 interrupt request lines into one processor interrupt. Software sees two words on a small 32-bit register bus: a cause word showing which lines are raised and an enable word choosing which of them may interrupt. Nearly every cause bit is a live copy of its synchronized request line. It has no memory of its own and clears when the source lets go.

One line is different. Bit 1 belongs to the front-panel reset switch. A press sets a sticky flag that stays up until software writes a one to that bit. The cause word also carries the live level of the switch in bit 16. A write of any value to a separate offset sends a one-cycle platform reset strobe. The controller also reports the index of the lowest-numbered pending line, so the handler does not have to scan for it.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset the enable word (offset 0x04) reads 0, `cpu_irq_o`, `plat_rst_o` and `pend_idx_o` are 0, and the cause word (offset 0x00) reads 0x0001_0000 while the switch is released.
- R2: For every line except bits 1 and 16, cause bit i follows `irq_req_i[i]` two clock edges after the input changes, and it drops by itself when the request drops. Request bits 1 and 16 never show in the cause word.
- R3: The enable word at offset 0x04 is written and read as a whole. A cause bit whose enable bit is 0 never raises `cpu_irq_o`.
- R4: A press of the switch sets cause bit 1. A press is a high-to-low change of `sw_level_i` after synchronization. Bit 1 stays set after the switch is released, and it clears only when a write to offset 0x00 has bit 1 set.
- R5: A write to offset 0x00 has no lasting effect on any level line's cause bit, and a write with bit 1 at 0 leaves the latched flag unchanged.
- R6: Cause bit 16 shows the synchronized switch level: 0 while pressed and 1 while released. Like any other cause bit, it can interrupt when its enable bit is set.
- R7: Every write to offset 0x24, whatever the data (0 included), drives `plat_rst_o` high for exactly the next cycle.
- R8: `cpu_irq_o` is the registered OR of (cause AND enable). It follows that value one cycle later.
- R9: `pend_idx_o` is registered together with `cpu_irq_o`. It gives the lowest bit number that is set in (cause AND enable), and it is 0 when nothing is pending.
- R10: Reads of offset 0x24 and of every offset not listed above return 0.
- R11: When a new press and a clearing write to bit 1 reach the latch in the same cycle, the latch stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req_i | input | 32 | Asynchronous level request lines |
| sw_level_i | input | 1 | Raw reset-switch level, 0 = pressed |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational while a read is strobed |
| cpu_irq_o | output | 1 | Combined interrupt to the processor |
| pend_idx_o | output | 5 | Lowest pending line number |
| plat_rst_o | output | 1 | One-cycle platform reset strobe |

## Verification
The properties assume that the bus inputs hold defined values at every clock edge, that addresses are word aligned, and that a write strobe lasts exactly one cycle. The properties also take request and switch inputs only through their synchronizers, so nothing is claimed about when a raw edge lands. The stimulus changes all inputs on the falling clock edge. It holds each request or switch level for at least three cycles, so every change passes through the full synchronizer and edge-detect chain before the next one. It places the clearing write against a second press only on the exact cycle that the edge detector fires.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  // Register offsets (byte addresses on the bus)
  localparam int OFS_CAUSE = 'h00;
  localparam int OFS_MASK  = 'h04;
  localparam int OFS_RESET = 'h24;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_CAUSE = 2'd1,
    SEL_MASK  = 2'd2,
    SEL_RESET = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/lvl_irq_sync.sv
// Multi-stage synchronizer with a per-bit reset value.
module lvl_irq_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q  [STAGES];
  logic [W-1:0] stg_nx [STAGES];

  always_comb begin
    stg_nx[0] = d_i;
    for (int s = 1; s < STAGES; s++) stg_nx[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_nx[s];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lvl_irq_cause.sv
// Builds the cause word: level lines, sticky switch flag, live switch level.
module lvl_irq_cause #(
  parameter int NLINES   = 32,
  parameter int RSW_BIT  = 1,
  parameter int SWST_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] req_s_i,   // synchronized requests
  input  logic              sw_s_i,    // synchronized switch level, 0 = pressed
  input  logic              clr_wr_i,  // write strobe to the cause word
  input  logic [NLINES-1:0] clr_data_i,
  output logic [NLINES-1:0] cause_o,
  output logic              latch_o
);
  localparam logic [NLINES-1:0] SPECIAL = (NLINES'(1) << RSW_BIT) | (NLINES'(1) << SWST_BIT);

  logic sw_d_q, sw_d_nx;
  logic latch_q, latch_nx;
  logic press, clr_hit;

  always_comb begin
    press    = sw_d_q & ~sw_s_i;
    clr_hit  = clr_wr_i & clr_data_i[RSW_BIT];
    sw_d_nx  = sw_s_i;
    // a fresh press wins over a clearing write in the same cycle
    latch_nx = press | (latch_q & ~clr_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_d_q  <= 1'b1;
      latch_q <= 1'b0;
    end else begin
      sw_d_q  <= sw_d_nx;
      latch_q <= latch_nx;
    end
  end

  logic [NLINES-1:0] special_v;
  for (genvar i = 0; i < NLINES; i++) begin : g_bit
    if (i == RSW_BIT) begin : g_rsw
      assign special_v[i] = latch_q;
    end else if (i == SWST_BIT) begin : g_swst
      assign special_v[i] = sw_s_i;
    end else begin : g_lvl
      assign special_v[i] = 1'b0;
    end
  end

  assign cause_o = (req_s_i & ~SPECIAL) | special_v;
  assign latch_o = latch_q;
endmodule

// File: rtl/lvl_irq_prio.sv
// Lowest-index-first priority finder.
module lvl_irq_prio #(
  parameter int NLINES = 32,
  localparam int IW    = $clog2(NLINES)
) (
  input  logic [NLINES-1:0] pend_i,
  output logic              any_o,
  output logic [IW-1:0]     idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IW'(i);
    end
    any_o = |pend_i;
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter int NLINES   = 32,
  parameter int AW       = 8,
  parameter int RSW_BIT  = 1,
  parameter int SWST_BIT = 16,
  parameter int SYNC_N   = 2,
  parameter bit HAS_IDX  = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NLINES-1:0]         irq_req_i,
  input  logic                      sw_level_i,
  input  logic                      bus_en_i,
  input  logic                      bus_we_i,
  input  logic [AW-1:0]             bus_addr_i,
  input  logic [NLINES-1:0]         bus_wdata_i,
  output logic [NLINES-1:0]         bus_rdata_o,
  output logic                      cpu_irq_o,
  output logic [$clog2(NLINES)-1:0] pend_idx_o,
  output logic                      plat_rst_o
);
  localparam int IW = $clog2(NLINES);
  localparam logic [NLINES-1:0] LVL_MASK = ~((NLINES'(1) << RSW_BIT) | (NLINES'(1) << SWST_BIT));

  // Reset: asserted asynchronously, released on the clock
  logic srst_n;
  lvl_irq_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(srst_n)
  );

  // Input synchronizers
  logic [NLINES-1:0] req_s;
  logic              sw_s;
  lvl_irq_sync #(.W(NLINES), .STAGES(SYNC_N), .RST_VAL('0)) u_req_sync (
    .clk(clk), .rst_n(srst_n), .d_i(irq_req_i & LVL_MASK), .q_o(req_s)
  );
  lvl_irq_sync #(.W(1), .STAGES(SYNC_N), .RST_VAL(1'b1)) u_sw_sync (
    .clk(clk), .rst_n(srst_n), .d_i(sw_level_i), .q_o(sw_s)
  );

  // Address decode
  reg_sel_e sel;
  logic     wr_cause, wr_mask, wr_rst, rd_en;
  always_comb begin
    if (bus_addr_i == AW'(OFS_CAUSE))      sel = SEL_CAUSE;
    else if (bus_addr_i == AW'(OFS_MASK))  sel = SEL_MASK;
    else if (bus_addr_i == AW'(OFS_RESET)) sel = SEL_RESET;
    else                                   sel = SEL_NONE;
    wr_cause = bus_en_i & bus_we_i & (sel == SEL_CAUSE);
    wr_mask  = bus_en_i & bus_we_i & (sel == SEL_MASK);
    wr_rst   = bus_en_i & bus_we_i & (sel == SEL_RESET);
    rd_en    = bus_en_i & ~bus_we_i;
  end

  // Cause word
  logic [NLINES-1:0] cause;
  logic              rsw_latch;
  lvl_irq_cause #(.NLINES(NLINES), .RSW_BIT(RSW_BIT), .SWST_BIT(SWST_BIT)) u_cause (
    .clk(clk), .rst_n(srst_n), .req_s_i(req_s), .sw_s_i(sw_s),
    .clr_wr_i(wr_cause), .clr_data_i(bus_wdata_i),
    .cause_o(cause), .latch_o(rsw_latch)
  );

  // Enable word, reset strobe, outputs: next state
  logic [NLINES-1:0] mask_q, mask_nx;
  logic              mask_en;
  logic              rst_q, rst_nx;
  logic              irq_q, irq_nx;
  logic [IW-1:0]     idx_q, idx_nx;
  logic [NLINES-1:0] pend_vec;

  always_comb begin
    mask_en  = wr_mask;
    mask_nx  = bus_wdata_i;
    rst_nx   = wr_rst;
    pend_vec = cause & mask_q;
  end

  if (HAS_IDX) begin : g_idx
    lvl_irq_prio #(.NLINES(NLINES)) u_prio (
      .pend_i(pend_vec), .any_o(irq_nx), .idx_o(idx_nx)
    );
  end else begin : g_noidx
    assign irq_nx = |pend_vec;
    assign idx_nx = '0;
  end

  // Registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      mask_q <= '0;
      rst_q  <= 1'b0;
      irq_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      if (mask_en) mask_q <= mask_nx;
      rst_q <= rst_nx;
      irq_q <= irq_nx;
      idx_q <= idx_nx;
    end
  end

  // Read mux
  always_comb begin
    bus_rdata_o = '0;
    if (rd_en) begin
      case (sel)
        SEL_CAUSE: bus_rdata_o = cause;
        SEL_MASK:  bus_rdata_o = mask_q;
        default:   bus_rdata_o = '0;
      endcase
    end
  end

  assign cpu_irq_o  = irq_q;
  assign pend_idx_o = idx_q;
  assign plat_rst_o = rst_q;
endmodule

// File: rtl/lvl_irq_chk.sv
module lvl_irq_chk #(
  parameter int NLINES  = 32,
  parameter int AW      = 8,
  parameter int RSW_BIT = 1,
  parameter int IW      = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [AW-1:0]     bus_addr,
  input logic [NLINES-1:0] bus_wdata,
  input logic [NLINES-1:0] pend_vec,
  input logic [NLINES-1:0] mask_q,
  input logic              latch,
  input logic              cpu_irq,
  input logic [IW-1:0]     pend_idx,
  input logic              plat_rst
);
  logic w_mask, w_cause, w_rst;
  assign w_mask  = bus_en && bus_we && (bus_addr == AW'('h04));
  assign w_cause = bus_en && bus_we && (bus_addr == AW'('h00));
  assign w_rst   = bus_en && bus_we && (bus_addr == AW'('h24));

  assert_mask_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    w_mask |=> (mask_q == $past(bus_wdata)));
  assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !w_mask |=> $stable(mask_q));
  assert_rsw_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && !(w_cause && bus_wdata[RSW_BIT])) |=> latch);
  assert_rst_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    w_rst |=> plat_rst);
  assert_rst_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    plat_rst |-> $past(w_rst));
  assert_irq_or_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cpu_irq == $past(|pend_vec)));
  assert_idx_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_irq |-> (pend_idx == '0));
endmodule

bind lvl_irq_ctrl lvl_irq_chk #(
  .NLINES(NLINES), .AW(AW), .RSW_BIT(RSW_BIT), .IW(IW)
) u_chk (
  .clk(clk), .rst_n(srst_n), .bus_en(bus_en_i), .bus_we(bus_we_i),
  .bus_addr(bus_addr_i), .bus_wdata(bus_wdata_i), .pend_vec(pend_vec),
  .mask_q(mask_q), .latch(rsw_latch), .cpu_irq(cpu_irq_o),
  .pend_idx(pend_idx_o), .plat_rst(plat_rst_o)
);

// File: tb/sim_lvl_irq_ctrl.sv
`timescale 1ns/1ps
module sim_lvl_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_req;
  logic        sw_level;
  logic        bus_en, bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        cpu_irq, plat_rst;
  logic [4:0]  pend_idx;

  always #2 clk = ~clk;

  lvl_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req), .sw_level_i(sw_level),
    .bus_en_i(bus_en), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .cpu_irq_o(cpu_irq),
    .pend_idx_o(pend_idx), .plat_rst_o(plat_rst)
  );

  // Scoreboard: 0 = read data, 1 = cpu_irq, 2 = pend_idx, 3 = plat_rst
  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sbq[$];
  event smp_ev;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  initial begin
    forever begin
      @(smp_ev);
      while (sbq.size() > 0) begin
        exp_t        e;
        logic [31:0] act;
        e = sbq.pop_front();
        case (e.sel)
          0:       act = bus_rdata;
          1:       act = {31'd0, cpu_irq};
          2:       act = {27'd0, pend_idx};
          default: act = {31'd0, plat_rst};
        endcase
        n_vec++;
        if (act !== e.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", e.tag, act, e.exp);
        end
      end
    end
  end

  task automatic chk(input int sel, input logic [31:0] exp, input string tag);
    exp_t e;
    e.sel = sel; e.exp = exp; e.tag = tag;
    sbq.push_back(e);
    -> smp_ev;
    #0.1;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #0.5;
    chk(0, exp, tag);
    bus_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_req = '0; sw_level = 1'b1;
    bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(6);

    // R1: reset state
    rd(8'h04, 32'h0, "R1 mask after reset");
    rd(8'h00, 32'h0001_0000, "R1 cause after reset");
    chk(1, 0, "R1 cpu_irq after reset");
    chk(2, 0, "R1 pend_idx after reset");
    chk(3, 0, "R1 plat_rst after reset");

    // R10: undefined and write-only offsets
    rd(8'h08, 32'h0, "R10 read 0x08");
    rd(8'h24, 32'h0, "R10 read 0x24");
    rd(8'h3C, 32'h0, "R10 read 0x3C");

    // R3: enable word
    wr(8'h04, 32'hFF00_00F0);
    rd(8'h04, 32'hFF00_00F0, "R3 mask readback");

    // R2 / R3: level line 8 while masked
    irq_req = 32'h0000_0100;
    tick(2);
    rd(8'h00, 32'h0001_0100, "R2 cause follows request");
    tick(1);
    chk(1, 0, "R3 masked line gives no irq");
    wr(8'h04, 32'hFF00_01F0);
    tick(1);
    chk(1, 1, "R8 irq after unmask");
    chk(2, 8, "R9 index of line 8");
    irq_req = 32'h0000_0120;
    tick(3);
    chk(2, 5, "R9 lowest line wins");
    chk(1, 1, "R8 irq with two lines");
    irq_req = 32'h0;
    tick(2);
    rd(8'h00, 32'h0001_0000, "R2 cause drops with source");
    tick(1);
    chk(1, 0, "R8 irq drops");
    chk(2, 0, "R9 idle index");

    // R2: request bits 1 and 16 are not level sources
    irq_req = 32'h0001_0002;
    tick(3);
    rd(8'h00, 32'h0001_0000, "R2 request bits 1 and 16 ignored");
    irq_req = 32'h0;

    // R5: write-ones to cause does not clear a level line
    irq_req = 32'h0000_0100;
    tick(3);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0001_0100, "R5 level bit survives write");
    chk(1, 1, "R5 irq still up");
    irq_req = 32'h0;
    tick(3);

    // R4 / R6: switch press
    wr(8'h04, 32'h0000_0002);
    sw_level = 1'b0;
    tick(2);
    rd(8'h00, 32'h0, "R6 pressed reads 0 in bit 16");
    tick(1);
    rd(8'h00, 32'h0000_0002, "R4 latch set on press");
    tick(1);
    chk(1, 1, "R4 irq from switch");
    chk(2, 1, "R9 index of switch line");
    sw_level = 1'b1;
    tick(3);
    rd(8'h00, 32'h0001_0002, "R4 latch holds after release");
    wr(8'h00, 32'hFFFF_FFFD);
    rd(8'h00, 32'h0001_0002, "R5 zero in bit 1 keeps latch");
    wr(8'h00, 32'h0000_0002);
    rd(8'h00, 32'h0001_0000, "R4 write one clears latch");
    tick(1);
    chk(1, 0, "R4 irq gone after clear");

    // R11: press and clear in the same cycle
    sw_level = 1'b0;
    tick(4);
    sw_level = 1'b1;
    tick(3);
    sw_level = 1'b0;
    tick(2);
    wr(8'h00, 32'h0000_0002);
    rd(8'h00, 32'h0000_0002, "R11 press beats clear");
    wr(8'h00, 32'h0000_0002);
    rd(8'h00, 32'h0000_0000, "R11 later clear works");
    sw_level = 1'b1;
    tick(3);
    rd(8'h00, 32'h0001_0000, "R6 released reads 1 in bit 16");

    // R6 / R8: bit 16 can interrupt when enabled
    wr(8'h04, 32'h0001_0000);
    tick(1);
    chk(1, 1, "R6 switch level interrupts");
    chk(2, 16, "R9 index 16");
    wr(8'h04, 32'h0);
    tick(1);
    chk(1, 0, "R8 irq off with mask 0");

    // R7: reset strobe
    wr(8'h24, 32'h0);
    chk(3, 1, "R7 strobe on zero write");
    tick(1);
    chk(3, 0, "R7 strobe one cycle");
    wr(8'h24, 32'hDEAD_BEEF);
    chk(3, 1, "R7 strobe on any data");
    wr(8'h04, 32'h0);
    chk(3, 0, "R7 no strobe on other write");

    #1;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule